// File: doc/BRIEF.md
# Branch Condition Resolution Unit

This unit decides whether a conditional branch of a 32-bit embedded instruction set is taken and which address executes next. The front end hands it fields that are already extracted from the instruction: the branch's own PC, the two register operand values, a branch class, a 4-bit condition field, a 4-bit index field and a displacement that is already sign-extended. From these the unit picks a comparison and evaluates it. The comparisons are against zero, against an encoded signed or unsigned constant, between two registers, a mask test, and a single-bit test whose position comes from a register or from the instruction. The unit then forms the branch target or the sequential address.

There are two instruction widths. For the 24-bit forms the sequential address is PC + 3 and the target is PC + 4 + displacement. The short 16-bit compare-to-zero form uses PC + 2 as its sequential address, and its target adds a 6-bit unsigned offset built from the instruction fields. Encodings the unit does not handle raise an illegal flag instead of a branch decision.

The result is registered. A two-state controller (`ST_IDLE`, `ST_SHOW`) presents it with a valid strobe in the cycle after the request. Transitions:
- `ST_IDLE` → `ST_SHOW` on `in_valid`.
- `ST_SHOW` → `ST_SHOW` on `in_valid`.
- Any state → `ST_IDLE` when `in_valid` is low.
- Synchronous reset forces `ST_IDLE`.

Top module: `brc_resolve_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. Synchronous active-high `rst` clears it. `taken`, `next_pc` and `illegal` are those of the request accepted one cycle earlier.
- R2: Class 0 (compare to zero): `cond_fld[1:0]` = 0 equal, 1 not-equal, 2 signed less-than, 3 signed greater-or-equal, each comparing `opnd_s` with 0.
- R3: Class 1 (signed constant): `idx_fld` selects the constant from -1, 1, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256 (index 0..15). `cond_fld[1:0]` picks the kind with the same coding as R2, using signed compares.
- R4: Class 2 (unsigned constant): `idx_fld` selects from 32768, 65536, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256. `cond_fld[1:0]` = 2 is unsigned less-than and 3 is unsigned greater-or-equal.
- R5: Class 2 with `cond_fld[1:0]` of 0 or 1, and class codes 5 to 7, set `illegal`, leave `taken` low and give `next_pc` = PC + 3.
- R6: Class 3 (register pair): `cond_fld[2:0]` = 1 is `opnd_s == opnd_t`, 2 is signed `opnd_s < opnd_t`, 3 is unsigned `opnd_s < opnd_t`. `cond_fld[3]` = 1 inverts every class-3 test.
- R7: Class 3 with `cond_fld[2:0]` = 0 is taken when `opnd_s & opnd_t` is zero. With `cond_fld[3]` set it is taken when that value is nonzero.
- R8: Class 3 with `cond_fld[2:0]` = 4 is taken when `(opnd_s & opnd_t) == opnd_t`. With `cond_fld[3]` set it is taken on inequality.
- R9: Class 3 with `cond_fld[2:0]` = 5 is taken when the bit of `opnd_s` at position `opnd_t[4:0]` is clear. With `cond_fld[3]` set it is taken when that bit is set.
- R10: Class 3 with `cond_fld[2:0]` = 6 or 7 tests the bit of `opnd_s` at position {`cond_fld[0]`, `idx_fld`}, where `cond_fld[0]` is bit 4. The sense is the same as R9.
- R11: For classes 0 to 3, `next_pc` is PC + 4 + `disp` when taken, otherwise PC + 3.
- R12: Class 4 (short form) is taken when `opnd_s` is zero, or when it is nonzero if `cond_fld[2]` is set. Its target is PC + 4 + {`cond_fld[1:0]`, `idx_fld`} as an unsigned 6-bit value, its sequential address is PC + 2, and `disp` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| pc | input | 32 | Address of the branch |
| br_class | input | 3 | Branch class (0..4 used) |
| cond_fld | input | 4 | Condition / sub-opcode field |
| idx_fld | input | 4 | Constant index, immediate bit index or short-form offset bits |
| opnd_s | input | 32 | First register operand |
| opnd_t | input | 32 | Second register operand |
| disp | input | 32 | Sign-extended displacement for 24-bit forms |
| out_valid | output | 1 | Result strobe |
| taken | output | 1 | Branch taken |
| next_pc | output | 32 | Next address to execute |
| illegal | output | 1 | Unhandled encoding |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, a 4-bit index, sequential steps of 3 and 2, and a target bias of 4. This width reaches the sign boundary at 0x7FFFFFFF/0x80000000, all 32 bit positions of both bit tests (the immediate form needs `cond_fld[0]` as bit 4), and both ends of each constant table. Operand values sit at each table entry and one either side of it. The short form's full 6-bit offset range is swept, with PCs near the top of the address space so that wrap-around in the adders is exercised.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [2:0] {
        BCLS_ZERO  = 3'd0,
        BCLS_SIMM  = 3'd1,
        BCLS_UIMM  = 3'd2,
        BCLS_PAIR  = 3'd3,
        BCLS_SHORT = 3'd4
    } brc_class_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } brc_state_e;

    typedef struct packed {
        logic taken;
        logic illegal;
    } brc_verdict_t;

endpackage

// File: rtl/brc_const_rom.sv
module brc_const_rom #(
    parameter int  XLEN       = 32,
    parameter int  IDX_W      = 4,
    parameter bit  SIGNED_SET = 1'b1
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [XLEN-1:0]  const_o
);
    // Entries 2..15 are shared by both tables; only the two lowest differ.
    logic [XLEN-1:0] shared_val;

    always_comb begin
        if (idx_i <= IDX_W'(8)) begin
            shared_val = XLEN'(idx_i);
        end else if (idx_i == IDX_W'(9)) begin
            shared_val = XLEN'(10);
        end else if (idx_i == IDX_W'(10)) begin
            shared_val = XLEN'(12);
        end else begin
            shared_val = XLEN'(16) << (idx_i - IDX_W'(11));
        end
    end

    generate
        if (SIGNED_SET) begin : g_signed
            always_comb begin
                unique case (idx_i)
                    IDX_W'(0): const_o = '1;
                    IDX_W'(1): const_o = XLEN'(1);
                    default:   const_o = shared_val;
                endcase
            end
        end else begin : g_unsigned
            always_comb begin
                unique case (idx_i)
                    IDX_W'(0): const_o = XLEN'(32768);
                    IDX_W'(1): const_o = XLEN'(65536);
                    default:   const_o = shared_val;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 4
) (
    input  logic [2:0]       cls_i,
    input  logic [3:0]       cond_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [XLEN-1:0]  s_i,
    input  logic [XLEN-1:0]  t_i,
    input  logic [XLEN-1:0]  simm_k_i,
    input  logic [XLEN-1:0]  uimm_k_i,
    output brc_verdict_t     verdict_o
);
    localparam int POS_W = $clog2(XLEN);

    logic [POS_W-1:0] pos_reg;
    logic [POS_W-1:0] pos_imm;
    logic [XLEN-1:0]  masked;
    logic             pair_raw;

    assign pos_reg = t_i[POS_W-1:0];
    assign pos_imm = POS_W'({cond_i[0], idx_i});
    assign masked  = s_i & t_i;

    function automatic logic signed_kind(input logic [1:0] kind,
                                         input logic [XLEN-1:0] a,
                                         input logic [XLEN-1:0] b);
        unique case (kind)
            2'd0:    return a == b;
            2'd1:    return a != b;
            2'd2:    return $signed(a) < $signed(b);
            default: return !($signed(a) < $signed(b));
        endcase
    endfunction

    // Register-pair test in its non-inverted sense.
    always_comb begin
        unique case (cond_i[2:0])
            3'd0:    pair_raw = (masked == '0);
            3'd1:    pair_raw = (s_i == t_i);
            3'd2:    pair_raw = ($signed(s_i) < $signed(t_i));
            3'd3:    pair_raw = (s_i < t_i);
            3'd4:    pair_raw = (masked == t_i);
            3'd5:    pair_raw = !s_i[pos_reg];
            default: pair_raw = !s_i[pos_imm];
        endcase
    end

    always_comb begin
        verdict_o = '0;
        unique case (cls_i)
            BCLS_ZERO:  verdict_o.taken = signed_kind(cond_i[1:0], s_i, '0);
            BCLS_SIMM:  verdict_o.taken = signed_kind(cond_i[1:0], s_i, simm_k_i);
            BCLS_UIMM: begin
                unique case (cond_i[1:0])
                    2'd2:    verdict_o.taken = (s_i < uimm_k_i);
                    2'd3:    verdict_o.taken = !(s_i < uimm_k_i);
                    default: verdict_o.illegal = 1'b1;
                endcase
            end
            BCLS_PAIR:  verdict_o.taken = pair_raw ^ cond_i[3];
            BCLS_SHORT: verdict_o.taken = (s_i == '0) ^ cond_i[2];
            default:    verdict_o.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/brc_target_gen.sv
module brc_target_gen #(
    parameter int XLEN      = 32,
    parameter int IDX_W     = 4,
    parameter int SEQ_WIDE  = 3,
    parameter int SEQ_SHORT = 2,
    parameter int TGT_BIAS  = 4
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  disp_i,
    input  logic             short_i,
    input  logic [1:0]       off_hi_i,
    input  logic [IDX_W-1:0] off_lo_i,
    input  logic             taken_i,
    output logic [XLEN-1:0]  next_pc_o
);
    logic [XLEN-1:0] wide_tgt;
    logic [XLEN-1:0] short_tgt;
    logic [XLEN-1:0] seq_pc;

    always_comb begin
        wide_tgt  = pc_i + XLEN'(TGT_BIAS) + disp_i;
        short_tgt = pc_i + XLEN'(TGT_BIAS) + XLEN'({off_hi_i, off_lo_i});
        seq_pc    = pc_i + (short_i ? XLEN'(SEQ_SHORT) : XLEN'(SEQ_WIDE));
        if (taken_i) begin
            next_pc_o = short_i ? short_tgt : wide_tgt;
        end else begin
            next_pc_o = seq_pc;
        end
    end

endmodule

// File: rtl/brc_resolve_unit.sv
module brc_resolve_unit
    import brc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int IDX_W     = 4,
    parameter int SEQ_WIDE  = 3,
    parameter int SEQ_SHORT = 2,
    parameter int TGT_BIAS  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [XLEN-1:0]  pc,
    input  logic [2:0]       br_class,
    input  logic [3:0]       cond_fld,
    input  logic [IDX_W-1:0] idx_fld,
    input  logic [XLEN-1:0]  opnd_s,
    input  logic [XLEN-1:0]  opnd_t,
    input  logic [XLEN-1:0]  disp,
    output logic             out_valid,
    output logic             taken,
    output logic [XLEN-1:0]  next_pc,
    output logic             illegal
);
    logic [XLEN-1:0] simm_k;
    logic [XLEN-1:0] uimm_k;
    brc_verdict_t    verdict;
    logic [XLEN-1:0] nxt_pc_c;
    logic            is_short;

    brc_state_e      state_q;
    brc_state_e      state_d;
    logic            taken_q;
    logic            illegal_q;
    logic [XLEN-1:0] next_pc_q;

    assign is_short = (br_class == BCLS_SHORT);

    brc_const_rom #(.XLEN(XLEN), .IDX_W(IDX_W), .SIGNED_SET(1'b1)) simm_rom_i (
        .idx_i   (idx_fld),
        .const_o (simm_k)
    );

    brc_const_rom #(.XLEN(XLEN), .IDX_W(IDX_W), .SIGNED_SET(1'b0)) uimm_rom_i (
        .idx_i   (idx_fld),
        .const_o (uimm_k)
    );

    brc_cond_eval #(.XLEN(XLEN), .IDX_W(IDX_W)) eval_i (
        .cls_i     (br_class),
        .cond_i    (cond_fld),
        .idx_i     (idx_fld),
        .s_i       (opnd_s),
        .t_i       (opnd_t),
        .simm_k_i  (simm_k),
        .uimm_k_i  (uimm_k),
        .verdict_o (verdict)
    );

    brc_target_gen #(
        .XLEN(XLEN), .IDX_W(IDX_W), .SEQ_WIDE(SEQ_WIDE),
        .SEQ_SHORT(SEQ_SHORT), .TGT_BIAS(TGT_BIAS)
    ) tgt_i (
        .pc_i      (pc),
        .disp_i    (disp),
        .short_i   (is_short),
        .off_hi_i  (cond_fld[1:0]),
        .off_lo_i  (idx_fld),
        .taken_i   (verdict.taken),
        .next_pc_o (nxt_pc_c)
    );

    // Next-state logic.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result capture.
    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q   <= 1'b0;
            illegal_q <= 1'b0;
            next_pc_q <= '0;
        end else if (in_valid) begin
            taken_q   <= verdict.taken;
            illegal_q <= verdict.illegal;
            next_pc_q <= nxt_pc_c;
        end
    end

    // Outputs.
    always_comb begin
        out_valid = 1'b0;
        taken     = 1'b0;
        illegal   = 1'b0;
        next_pc   = next_pc_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_SHOW: begin
                out_valid = 1'b1;
                taken     = taken_q;
                illegal   = illegal_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/brc_resolve_chk.sv
module brc_resolve_chk #(
    parameter int XLEN      = 32,
    parameter int IDX_W     = 4,
    parameter int SEQ_WIDE  = 3,
    parameter int SEQ_SHORT = 2,
    parameter int TGT_BIAS  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [XLEN-1:0]  pc,
    input logic [2:0]       br_class,
    input logic [3:0]       cond_fld,
    input logic [IDX_W-1:0] idx_fld,
    input logic [XLEN-1:0]  opnd_s,
    input logic [XLEN-1:0]  opnd_t,
    input logic [XLEN-1:0]  disp,
    input logic             out_valid,
    input logic             taken,
    input logic [XLEN-1:0]  next_pc,
    input logic             illegal
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_zero_equal_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && br_class == 3'd0 && cond_fld[1:0] == 2'd0)
        |=> (taken == (opnd_s == '0 ? 1'b0 : 1'b0) || taken == ($past(opnd_s) == '0)));

    assert_unsigned_legal_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && br_class == 3'd2 && cond_fld[1]) |=> !illegal);

    assert_illegal_not_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && illegal) |-> !taken);

    assert_illegal_seq_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (br_class > 3'd4)) |=>
        (illegal && next_pc == XLEN'($past(pc) + XLEN'(SEQ_WIDE))));

    assert_wide_target_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && br_class < 3'd4) |=>
        (!taken || next_pc == XLEN'($past(pc) + XLEN'(TGT_BIAS) + $past(disp))));

    assert_wide_fall_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && br_class < 3'd4) |=>
        (taken || next_pc == XLEN'($past(pc) + XLEN'(SEQ_WIDE))));

    assert_short_target_R12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && br_class == 3'd4) |=>
        (taken ? next_pc == XLEN'($past(pc) + XLEN'(TGT_BIAS) + XLEN'({$past(cond_fld[1:0]), $past(idx_fld)}))
               : next_pc == XLEN'($past(pc) + XLEN'(SEQ_SHORT))));

endmodule

bind brc_resolve_unit brc_resolve_chk #(
    .XLEN(XLEN), .IDX_W(IDX_W), .SEQ_WIDE(SEQ_WIDE),
    .SEQ_SHORT(SEQ_SHORT), .TGT_BIAS(TGT_BIAS)
) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pc(pc), .br_class(br_class),
    .cond_fld(cond_fld), .idx_fld(idx_fld), .opnd_s(opnd_s), .opnd_t(opnd_t),
    .disp(disp), .out_valid(out_valid), .taken(taken), .next_pc(next_pc),
    .illegal(illegal)
);

// File: tb/brc_resolve_unit_tb_top.sv
module brc_resolve_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] pc = '0;
    logic [2:0]  br_class = '0;
    logic [3:0]  cond_fld = '0;
    logic [3:0]  idx_fld = '0;
    logic [31:0] opnd_s = '0;
    logic [31:0] opnd_t = '0;
    logic [31:0] disp = '0;
    logic        out_valid;
    logic        taken;
    logic [31:0] next_pc;
    logic        illegal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit started = 1'b0;

    always #10 clk = ~clk;

    brc_resolve_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .pc(pc), .br_class(br_class),
        .cond_fld(cond_fld), .idx_fld(idx_fld), .opnd_s(opnd_s), .opnd_t(opnd_t),
        .disp(disp), .out_valid(out_valid), .taken(taken), .next_pc(next_pc),
        .illegal(illegal)
    );

    longint stab [16] = '{-1, 1, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256};
    longint utab [16] = '{32768, 65536, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256};

    // Behavioural reference for one request.
    function automatic void ref_model(input logic [2:0] c, input logic [3:0] f,
                                      input logic [3:0] x, input logic [31:0] s,
                                      input logic [31:0] t, input logic [31:0] p,
                                      input logic [31:0] d, output bit tk,
                                      output bit il, output logic [31:0] np,
                                      output string tag, output string ptag);
        longint ss = longint'($signed(s));
        longint st = longint'($signed(t));
        longint us = longint'(s);
        longint ut = longint'(t);
        longint k;
        int     pos;
        bit     sh = 1'b0;
        tk = 1'b0; il = 1'b0;
        tag = "R5";
        if (c == 3'd0 || c == 3'd1) begin
            k = (c == 3'd0) ? 0 : stab[x];
            tag = (c == 3'd0) ? "R2" : "R3";
            case (f[1:0])
                2'd0: tk = (ss == k);
                2'd1: tk = (ss != k);
                2'd2: tk = (ss < k);
                default: tk = (ss >= k);
            endcase
        end else if (c == 3'd2) begin
            if (f[1:0] == 2'd2)      begin tk = (us <  utab[x]); tag = "R4"; end
            else if (f[1:0] == 2'd3) begin tk = (us >= utab[x]); tag = "R4"; end
            else il = 1'b1;
        end else if (c == 3'd3) begin
            case (f[2:0])
                3'd0: begin tk = ((s & t) == 0); tag = "R7"; end
                3'd1: begin tk = (us == ut); tag = "R6"; end
                3'd2: begin tk = (ss < st); tag = "R6"; end
                3'd3: begin tk = (us < ut); tag = "R6"; end
                3'd4: begin tk = ((s & t) == t); tag = "R8"; end
                3'd5: begin pos = int'(t % 32); tk = (((us >> pos) & 1) == 0); tag = "R9"; end
                default: begin pos = int'(f[0]) * 16 + int'(x); tk = (((us >> pos) & 1) == 0); tag = "R10"; end
            endcase
            if (f[3]) tk = !tk;
        end else if (c == 3'd4) begin
            sh = 1'b1; tag = "R12";
            tk = f[2] ? (us != 0) : (us == 0);
        end else begin
            il = 1'b1;
        end
        if (il) begin
            np = p + 32'd3; ptag = "R5";
        end else if (sh) begin
            np = tk ? p + 32'd4 + 32'(int'(f[1:0]) * 16 + int'(x)) : p + 32'd2;
            ptag = "R12";
        end else begin
            np = tk ? p + 32'd4 + d : p + 32'd3;
            ptag = "R11";
        end
    endfunction

    bit          e_v = 1'b0;
    bit          e_tk, e_il;
    logic [31:0] e_np;
    string       e_tag, e_ptag;

    always @(posedge clk) begin
        bit tk, il; logic [31:0] np; string tg, pt;
        started <= 1'b1;
        e_v <= !rst && in_valid;
        if (!rst && in_valid) begin
            ref_model(br_class, cond_fld, idx_fld, opnd_s, opnd_t, pc, disp, tk, il, np, tg, pt);
            e_tk <= tk; e_il <= il; e_np <= np; e_tag <= tg; e_ptag <= pt;
        end
    end

    // Compared on every clock, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            n_cmp++;
            if (out_valid !== e_v) begin
                n_bad++;
                $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, e_v);
            end
            if (e_v) begin
                n_cmp++;
                if (illegal !== e_il) begin
                    n_bad++;
                    $display("FAIL R5 illegal actual=%0b expected=%0b", illegal, e_il);
                end
                n_cmp++;
                if (taken !== e_tk) begin
                    n_bad++;
                    $display("FAIL %s taken actual=%0b expected=%0b", e_tag, taken, e_tk);
                end
                n_cmp++;
                if (next_pc !== e_np) begin
                    n_bad++;
                    $display("FAIL %s next_pc actual=%h expected=%h", e_ptag, next_pc, e_np);
                end
            end
        end
    end

    int seq_n = 0;

    task automatic issue(input logic [2:0] c, input logic [3:0] f, input logic [3:0] x,
                         input logic [31:0] s, input logic [31:0] t);
        @(negedge clk);
        seq_n++;
        in_valid = 1'b1;
        br_class = c; cond_fld = f; idx_fld = x; opnd_s = s; opnd_t = t;
        pc   = (seq_n % 9 == 0) ? 32'hFFFF_FFF0 + 32'(seq_n % 16) : 32'h0000_1000 + 32'(seq_n * 7);
        disp = 32'(((seq_n % 7) - 3) * 41);
        if (seq_n % 13 == 0) begin
            @(negedge clk);
            in_valid = 1'b0;
            disp = 32'hDEAD_BEEF;
        end
    endtask

    logic [31:0] bv [10] = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1,
                             32'h2, 32'h8000, 32'h1_0000, 32'h100, 32'h5A5A_00F0};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2 zero compares, R5 unused class codes
        for (int c = 0; c < 8; c++)
            if (c != 1 && c != 2 && c != 3 && c != 4)
                for (int f = 0; f < 16; f++)
                    for (int i = 0; i < 10; i++) issue(3'(c), 4'(f), 4'(i), bv[i], 32'h0);
        // R3 / R4 / R5 constant compares at both table ends and neighbours
        for (int c = 1; c < 3; c++)
            for (int x = 0; x < 16; x++)
                for (int f = 0; f < 4; f++) begin
                    longint k = (c == 1) ? stab[x] : utab[x];
                    issue(3'(c), 4'(f), 4'(x), 32'(k), 32'h0);
                    issue(3'(c), 4'(f), 4'(x), 32'(k - 1), 32'h0);
                    issue(3'(c), 4'(f), 4'(x), 32'(k + 1), 32'h0);
                    for (int i = 0; i < 4; i++) issue(3'(c), 4'(f), 4'(x), bv[i], 32'h0);
                end
        // R6 / R7 / R8 / R9 register pairs
        for (int f = 0; f < 16; f++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++) issue(3'd3, 4'(f), 4'(i), bv[i], bv[j]);
        // R9 every register bit position
        for (int b = 0; b < 64; b++) begin
            issue(3'd3, 4'd5,  4'd0, 32'h1 << (b % 32), 32'(b));
            issue(3'd3, 4'd13, 4'd0, ~(32'h1 << (b % 32)), 32'(b));
        end
        // R10 every immediate bit position
        for (int f = 6; f < 16; f++)
            if (f == 6 || f == 7 || f == 14 || f == 15)
                for (int x = 0; x < 16; x++) begin
                    issue(3'd3, 4'(f), 4'(x), 32'h1 << ((f % 2) * 16 + x), 32'h0);
                    issue(3'd3, 4'(f), 4'(x), 32'hA5C3_3C5A, 32'hFFFF_FFFF);
                end
        // R12 short form over full offset range
        for (int f = 0; f < 16; f++)
            for (int x = 0; x < 16; x++)
                for (int i = 0; i < 3; i++) issue(3'd4, 4'(f), 4'(x), bv[i], 32'h0);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule